// File: doc/BRIEF.md
# Multi-channel PS/2 shift controller

A single PS/2 frame engine is shared by four open-collector PS/2 ports. Each port has its own clock line and data line. A small register interface lets the host release or hold each line, choose receive or transmit mode, set the input filter, read status and exchange the data byte. Lines are open-drain: the block asserts an output-enable only when it pulls a line low.

In receive mode the engine waits for a start bit on any port whose clock is released. The first port to show one owns the engine until the host resets it. The engine shifts in eight data bits, LSB first, followed by an odd parity bit and a stop bit. It then flags end-of-transaction and latches the byte.

In transmit mode the host loads the data byte and issues a request-to-send on one port. That port then takes the start bit from the engine. On each falling clock edge from the device the engine drives the next data bit, then parity, then releases the line for the stop bit. On the eleventh falling edge it checks for the device acknowledge.

The transaction flags, the error flags and the owning channel stay set until the host holds every port clock low. That action resets the shift mechanism.

Top module: `ps2_shift_hub`

## Requirements
- R1: After reset the line register reads 0x47, so all four clock outputs pull low and no data output pulls low. The status register reads 0 and `irq` is low.
- R2: The line register (offset 1) holds data-release bits at positions 0, 1, 2 and 6 for ports 0 to 3, and clock-release bits at positions 3, 4, 5 and 7. A clear bit makes that port's output-enable pull the line low.
- R3: In receive mode (control bit 1 clear) a frame is a start bit of 0, eight data bits LSB first, a parity bit and a stop bit, each sampled on a falling edge of the filtered port clock. After the stop bit, status bit 1 (end-of-transaction) sets and the data register (offset 3) returns the byte.
- R4: Status bits [6:4] give the owning port as 1, 2, 4 or 5 for ports 0, 1, 2 and 3. The first released port to show a start bit wins. Frames on any other port are ignored until the shift mechanism is reset.
- R5: Status bit 2 sets when data plus parity hold an even number of ones. Status bit 3 sets when the received stop bit is 0.
- R6: Status bit 0 (start-of-transaction) sets at the start bit and stays set. Clearing every clock-release bit clears status bits 0 to 6.
- R7: In transmit mode (control bit 1 set), a port with its clock-release bit set and its data-release bit clear starts a transmission. The engine drives the start bit at once, then one data bit (LSB first) after each of the first eight falling edges, odd parity after the ninth, and releases the line after the tenth. If data is low at the eleventh edge, end-of-transaction sets and the frame-error bit stays clear.
- R8: If data is high at the eleventh transmit edge, end-of-transaction and the frame-error bit both set.
- R9: `irq` is high exactly when (start-of-transaction and interrupt-enable bit 0) or (end-of-transaction and interrupt-enable bit 1). The interrupt-enable register sits at offset 4.
- R10: While control bit 0 (master enable) is clear, the engine stays idle and start bits are ignored.
- R11: Control bits [4:2] select a filter window of 2^sel sample cycles (1 to 32). A clock pulse shorter than the window does not reach the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 control, 1 lines, 2 status, 3 data, 4 interrupt enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ps2_clk_in | input | 4 | Sensed clock line of each port |
| ps2_dat_in | input | 4 | Sensed data line of each port |
| ps2_clk_oe | output | 4 | Pull clock line low, one per port |
| ps2_dat_oe | output | 4 | Pull data line low, one per port |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default filter counter width of 5 bits, so the full 32-cycle window is available. The bench switches between select 5 and select 0 at run time. A 10-cycle clock glitch is therefore rejected by the widest window and accepted by the narrowest one, and every received frame also passes through the slowest filter. Device half periods of 40 cycles keep every bit longer than the widest window plus synchroniser delay.

// File: rtl/ps2_hub_pkg.sv
package ps2_hub_pkg;
    localparam int PORTS = 4;
    localparam int BYTE_W = 8;

    typedef logic [1:0] port_t;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_LINES = 3'd1;
    localparam logic [2:0] ADR_STAT  = 3'd2;
    localparam logic [2:0] ADR_DATA  = 3'd3;
    localparam logic [2:0] ADR_IEN   = 3'd4;

    // all data lines released, all clocks held low
    localparam logic [7:0] LINES_RST = 8'h47;

    function automatic int clk_pos(input int p);
        return (p == 3) ? 7 : 3 + p;
    endfunction

    function automatic int dat_pos(input int p);
        return (p == 3) ? 6 : p;
    endfunction

    function automatic logic [2:0] chan_code(input port_t p);
        return (p < 2'd2) ? 3'(p) + 3'd1 : 3'(p) + 3'd2;
    endfunction
endpackage

// File: rtl/ps2_glitch_filter.sv
module ps2_glitch_filter #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       raw,
    output logic       filt
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             filt;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t q, d;
    logic [2:0]       shamt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        shamt = (sel > 3'(CNT_W)) ? 3'(CNT_W) : sel;
        lim   = CNT_W'((32'd1 << shamt) - 32'd1);
        d     = q;
        d.s1  = raw;
        d.s2  = q.s1;
        if (q.s2 == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt >= lim) begin
            d.filt = q.s2;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, cnt: '0};
        else        q <= d;
    end

    assign filt = q.filt;

    // R11: the filtered level only moves to a value the synchroniser held
    p_filter_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.filt != $past(q.filt)) |-> ($past(q.s2) == q.filt));
endmodule

// File: rtl/ps2_frame_engine.sv
module ps2_frame_engine
    import ps2_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              xmit,
    input  logic [PORTS-1:0]  clk_rel,
    input  logic [PORTS-1:0]  dat_rel,
    input  logic [PORTS-1:0]  clk_f,
    input  logic [PORTS-1:0]  dat_f,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sot,
    output logic              eot,
    output logic              perr,
    output logic              ferr,
    output port_t             act,
    output logic              tx_own,
    output logic              tx_low,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte
);
    typedef struct packed {
        logic              sot;
        logic              eot;
        logic              perr;
        logic              ferr;
        port_t             act;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              par;
        logic              tx_low;
        logic              txm;
        logic [PORTS-1:0]  cprev;
    } eng_t;

    eng_t q, d;
    logic [PORTS-1:0] fall, cand;
    logic             mech_rst, hit, dbit, efall;
    port_t            pick;

    assign mech_rst = !enable || (clk_rel == '0);

    always_comb begin
        d       = q;
        d.cprev = clk_f;
        rx_load = 1'b0;
        fall    = q.cprev & ~clk_f & clk_rel;
        cand    = xmit ? (clk_rel & ~dat_rel) : (fall & ~dat_f);
        pick    = '0;
        hit     = 1'b0;
        for (int i = PORTS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick = port_t'(i);
                hit  = 1'b1;
            end
        end
        dbit  = dat_f[q.act];
        efall = fall[q.act];

        if (mech_rst) begin
            d       = '0;
            d.cprev = clk_f;
        end else if (!q.sot) begin
            if (hit) begin
                d.sot = 1'b1;
                d.act = pick;
                d.txm = xmit;
                if (xmit) begin
                    d.cnt    = 4'd0;
                    d.sh     = tx_byte;
                    d.par    = ~^tx_byte;
                    d.tx_low = 1'b1;
                end else begin
                    d.cnt = 4'd1;
                end
            end
        end else if (!q.eot && efall) begin
            d.cnt = q.cnt + 4'd1;
            if (q.txm) begin
                if (q.cnt < 4'd8) begin
                    d.tx_low = ~q.sh[0];
                    d.sh     = q.sh >> 1;
                end else if (q.cnt == 4'd8) begin
                    d.tx_low = ~q.par;
                end else if (q.cnt == 4'd9) begin
                    d.tx_low = 1'b0;
                end else begin
                    d.eot  = 1'b1;
                    d.ferr = dbit;
                end
            end else begin
                if (q.cnt <= 4'd8) begin
                    d.sh = {dbit, q.sh[BYTE_W-1:1]};
                end else if (q.cnt == 4'd9) begin
                    d.perr = ~(^q.sh ^ dbit);
                end else begin
                    d.ferr  = ~dbit;
                    d.eot   = 1'b1;
                    rx_load = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sot     = q.sot;
    assign eot     = q.eot;
    assign perr    = q.perr;
    assign ferr    = q.ferr;
    assign act     = q.act;
    assign tx_own  = q.sot && q.txm;
    assign tx_low  = q.tx_low;
    assign rx_byte = q.sh;

    p_eot_after_sot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.eot |-> q.sot);
    p_mech_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mech_rst |=> (!q.sot && !q.eot && !q.perr && !q.ferr));
    p_owner_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sot && $past(q.sot)) |-> (q.act == $past(q.act)));
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !q.sot);
    p_drive_in_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.tx_low |-> (q.sot && q.txm && !q.eot));
endmodule

// File: rtl/ps2_shift_hub.sv
module ps2_shift_hub
    import ps2_hub_pkg::*;
#(
    parameter int DB_CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [PORTS-1:0] ps2_clk_in,
    input  logic [PORTS-1:0] ps2_dat_in,
    output logic [PORTS-1:0] ps2_clk_oe,
    output logic [PORTS-1:0] ps2_dat_oe,
    output logic             irq
);
    typedef struct packed {
        logic        en;
        logic        xmit;
        logic [2:0]  dbsel;
        logic [7:0]  lines;
        logic [BYTE_W-1:0] data;
        logic [1:0]  ien;
    } regs_t;

    regs_t q, d;

    logic [PORTS-1:0]  clk_rel, dat_rel, clk_f, dat_f;
    logic              e_sot, e_eot, e_perr, e_ferr, tx_own, tx_low, rx_load;
    port_t             e_act;
    logic [BYTE_W-1:0] rx_byte;
    logic [2:0]        code;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign clk_rel[p]    = q.lines[clk_pos(p)];
        assign dat_rel[p]    = q.lines[dat_pos(p)];
        assign ps2_clk_oe[p] = ~clk_rel[p];
        assign ps2_dat_oe[p] = (tx_own && e_act == port_t'(p)) ? tx_low : ~dat_rel[p];

        ps2_glitch_filter #(.CNT_W(DB_CNT_W)) u_clk_flt (
            .clk(clk), .rst_n(rst_n), .sel(q.dbsel),
            .raw(ps2_clk_in[p]), .filt(clk_f[p]));
        ps2_glitch_filter #(.CNT_W(DB_CNT_W)) u_dat_flt (
            .clk(clk), .rst_n(rst_n), .sel(q.dbsel),
            .raw(ps2_dat_in[p]), .filt(dat_f[p]));
    end

    ps2_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .enable(q.en), .xmit(q.xmit),
        .clk_rel(clk_rel), .dat_rel(dat_rel), .clk_f(clk_f), .dat_f(dat_f),
        .tx_byte(q.data), .sot(e_sot), .eot(e_eot), .perr(e_perr), .ferr(e_ferr),
        .act(e_act), .tx_own(tx_own), .tx_low(tx_low), .rx_load(rx_load),
        .rx_byte(rx_byte));

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL:  begin
                    d.en    = reg_wdata[0];
                    d.xmit  = reg_wdata[1];
                    d.dbsel = reg_wdata[4:2];
                end
                ADR_LINES: d.lines = reg_wdata;
                ADR_DATA:  d.data  = reg_wdata;
                ADR_IEN:   d.ien   = reg_wdata[1:0];
                default:   ;
            endcase
        end
        if (rx_load) d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{en: 1'b0, xmit: 1'b0, dbsel: 3'd0, lines: LINES_RST,
                           data: '0, ien: 2'b00};
        else        q <= d;
    end

    assign code = e_sot ? chan_code(e_act) : 3'd0;

    always_comb begin
        case (reg_addr)
            ADR_CTRL:  reg_rdata = {3'b000, q.dbsel, q.xmit, q.en};
            ADR_LINES: reg_rdata = q.lines;
            ADR_STAT:  reg_rdata = {1'b0, code, e_ferr, e_perr, e_eot, e_sot};
            ADR_DATA:  reg_rdata = q.data;
            ADR_IEN:   reg_rdata = {6'b0, q.ien};
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign irq = (e_sot && q.ien[0]) || (e_eot && q.ien[1]);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (e_sot || e_eot));
    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_own && e_eot) |-> (ps2_dat_oe[e_act] == 1'b0));
    p_load_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (q.data == $past(rx_byte)));
endmodule

// File: tb/ps2_shift_hub_test.sv
module ps2_shift_hub_test;
    localparam int H = 40;

    logic       clk = 1'b0;
    logic       rst_n, reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [3:0] clk_oe, dat_oe, dclk, ddat, clk_in, dat_in;
    logic       irq;

    always #5 clk = ~clk;

    assign clk_in = dclk & ~clk_oe;
    assign dat_in = ddat & ~dat_oe;

    ps2_shift_hub uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ps2_clk_in(clk_in),
        .ps2_dat_in(dat_in), .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe), .irq(irq));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        logic [7:0] st;
        logic [7:0] dat;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    function automatic int cpos(input int c); return (c == 3) ? 7 : 3 + c; endfunction
    function automatic int dpos(input int c); return (c == 3) ? 6 : c;     endfunction
    function automatic logic [2:0] ccode(input int c);
        return (c < 2) ? 3'(c + 1) : 3'(c + 2);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic restart();
        wr(3'd1, 8'h47);
        repeat (10) @(negedge clk);
        wr(3'd1, 8'hFF);
        repeat (60) @(negedge clk);
    endtask

    // driver: plays a frame as a device, pushes the expected result for full frames
    task automatic rx_frame(input int ch, input logic [7:0] b, input bit bad_par,
                            input bit stop_v, input int nbits, input string tag);
        logic [10:0] bits;
        bits = {stop_v, ~^b ^ bad_par, b, 1'b0};
        for (int k = 0; k < nbits; k++) begin
            ddat[ch] = bits[k];
            half();
            dclk[ch] = 1'b0;
            half();
            dclk[ch] = 1'b1;
        end
        ddat[ch] = 1'b1;
        half();
        repeat (40) @(negedge clk);
        if (nbits == 11)
            sbq.push_back('{st: {1'b0, ccode(ch), ~stop_v, bad_par, 2'b11}, dat: b, tag: tag});
    endtask

    // monitor side of the scoreboard
    task automatic check_sb();
        exp_t e;
        logic [7:0] s, v;
        e = sbq.pop_front();
        rd(3'd2, s);
        rd(3'd3, v);
        chk({e.tag, " status"}, s, e.st);
        chk({e.tag, " data"}, v, e.dat);
    endtask

    task automatic tx_send(input int ch, input logic [7:0] b, input bit ack,
                           output logic [7:0] gb, output logic gp, output logic gs);
        wr(3'd0, 8'h03);
        wr(3'd3, b);
        wr(3'd1, (8'h47 & ~(8'd1 << dpos(ch))) | (8'd1 << cpos(ch)));
        half();
        for (int k = 1; k <= 10; k++) begin
            dclk[ch] = 1'b0;
            half();
            dclk[ch] = 1'b1;
            if (k <= 8)       gb[k-1] = dat_in[ch];
            else if (k == 9)  gp = dat_in[ch];
            else              gs = dat_in[ch];
            half();
        end
        if (ack) ddat[ch] = 1'b0;
        half();
        dclk[ch] = 1'b0;
        half();
        dclk[ch] = 1'b1;
        ddat[ch] = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, gb;
        logic gp, gs;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        dclk = 4'hF; ddat = 4'hF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, v);   chk("R1 lines", v, 8'h47);
        rd(3'd2, v);   chk("R1 status", v, 8'h00);
        chk("R1 clk_oe", {4'h0, clk_oe}, 8'h0F);
        chk("R1 dat_oe", {4'h0, dat_oe}, 8'h00);
        chk("R1 irq", {7'h0, irq}, 8'h00);

        // R2 bit positions
        wr(3'd1, 8'hB8);
        chk("R2 clocks released", {4'h0, clk_oe}, 8'h00);
        chk("R2 data held", {4'h0, dat_oe}, 8'h0F);
        wr(3'd1, 8'h40);
        chk("R2 port3 data only", {4'h0, dat_oe}, 8'h07);
        chk("R2 port3 clk", {4'h0, clk_oe}, 8'h0F);

        wr(3'd0, 8'h15);
        wr(3'd4, 8'h03);
        restart();

        // R3 / R4 good frames on every port
        rx_frame(0, 8'hA5, 0, 1, 11, "R3 port0 0xA5");
        check_sb();
        chk("R9 irq on eot", {7'h0, irq}, 8'h01);
        wr(3'd1, 8'h47);
        rd(3'd2, v); chk("R6 reset clears status", v, 8'h00);
        chk("R9 irq after reset", {7'h0, irq}, 8'h00);
        restart();
        rx_frame(2, 8'h3C, 0, 1, 11, "R4 port2 code");
        check_sb(); restart();
        rx_frame(3, 8'h00, 0, 1, 11, "R4 port3 code");
        check_sb(); restart();
        rx_frame(1, 8'hFF, 0, 1, 11, "R4 port1 code");
        check_sb(); restart();

        // R5 errors
        rx_frame(1, 8'h5A, 1, 1, 11, "R5 parity error");
        check_sb(); restart();
        rx_frame(0, 8'h81, 0, 0, 11, "R5 frame error");
        check_sb(); restart();

        // R6 sot holds, R4 winner keeps engine
        rx_frame(3, 8'h00, 0, 1, 1, "start only");
        rd(3'd2, v); chk("R6 sot after start", v, 8'h51);
        rx_frame(0, 8'h77, 0, 1, 11, "loser");
        void'(sbq.pop_back());
        rd(3'd2, v); chk("R4 other port ignored", v, 8'h51);
        rd(3'd3, v); chk("R4 data untouched", v, 8'h81);

        // R9 gating with only sot set
        wr(3'd4, 8'h00); chk("R9 no enables", {7'h0, irq}, 8'h00);
        wr(3'd4, 8'h02); chk("R9 eot enable only", {7'h0, irq}, 8'h00);
        wr(3'd4, 8'h01); chk("R9 sot enable", {7'h0, irq}, 8'h01);
        restart();

        // R10 master enable clear
        wr(3'd0, 8'h14);
        rx_frame(0, 8'h12, 0, 1, 11, "disabled");
        void'(sbq.pop_back());
        rd(3'd2, v); chk("R10 disabled ignores start", v, 8'h00);
        wr(3'd0, 8'h15);
        restart();

        // R11 filter window
        ddat[0] = 1'b0; repeat (5) @(negedge clk);
        dclk[0] = 1'b0; repeat (10) @(negedge clk);
        dclk[0] = 1'b1; repeat (5) @(negedge clk);
        ddat[0] = 1'b1; repeat (80) @(negedge clk);
        rd(3'd2, v); chk("R11 glitch rejected at 32", v, 8'h00);
        wr(3'd0, 8'h01);
        repeat (10) @(negedge clk);
        ddat[0] = 1'b0; repeat (5) @(negedge clk);
        dclk[0] = 1'b0; repeat (10) @(negedge clk);
        dclk[0] = 1'b1; repeat (5) @(negedge clk);
        ddat[0] = 1'b1; repeat (20) @(negedge clk);
        rd(3'd2, v); chk("R11 pulse seen at 1", v, 8'h11);
        restart();

        // R7 transmit with acknowledge
        tx_send(2, 8'h96, 1, gb, gp, gs);
        chk("R7 tx byte", gb, 8'h96);
        chk("R7 tx parity", {7'h0, gp}, {7'h0, ~^8'h96});
        chk("R7 tx stop", {7'h0, gs}, 8'h01);
        rd(3'd2, v); chk("R7 tx status", v, 8'h43);
        chk("R7 data released", {4'h0, dat_oe}, 8'h00);
        wr(3'd1, 8'h47);

        // R8 transmit without acknowledge
        tx_send(0, 8'h01, 0, gb, gp, gs);
        chk("R8 tx byte", gb, 8'h01);
        rd(3'd2, v); chk("R8 no ack status", v, 8'h1B);
        wr(3'd1, 8'h47);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule